// File: doc/BRIEF.md
# Multi-mode 8-bit timer/counter

This block is an 8-bit up-counter paired with a compare register. It runs in one of three modes. In interval timer mode it counts ticks from an internal prescaler. In event counting mode it counts rising edges of an external pin. In square-wave divider mode it inverts an output pin on every compare match, which gives a 50% duty waveform. Every match clears the counter and raises a one-cycle interrupt pulse. The counter then keeps running.

The whole block runs on the system clock. The prescaler does not create a derived clock. It issues a one-cycle enable pulse whose spacing is a power of two, chosen by a 3-bit clock select and a range bit. The external pin is resynchronized before its edges are detected. Software writes two registers through a single write port: a control byte and the compare value. Setting the run bit starts the block from a known state. Clearing it parks the counter at zero and the output low.

Top module: `tmr_top`

## Requirements
- R1: Writing with `wr_addr`=0 loads the control byte: bits [1:0] select the mode (00 interval timer, 01 event counting, 10 square-wave divider, 11 behaves as 00), bits [4:2] are the clock select, bit 5 is the range bit and bit 7 is run. Bit 6 is ignored. Writing with `wr_addr`=1 loads the 8-bit compare value.
- R2: The source tick period is 2^E system clocks. E is 11, 7, 5 or 3 for clock select 0, 1, 2 or 3, codes 4 to 7 act as code 3, and the range bit adds 1 to E. The first tick of a run comes 2^E cycles after the write that sets run.
- R3: In interval timer mode, each tick advances the counter. When the advanced value would equal the compare value, the counter clears instead and an interrupt is raised, so interrupts are spaced compare×2^E cycles apart. The first interrupt is visible in the cycle after the clock edge at which that many cycles have elapsed since the start.
- R4: A compare value of 0 gives a match on every source tick in interval timer and square-wave divider modes.
- R5: In event counting mode the counter advances only on rising edges of the synchronized external pin. Prescaler ticks have no effect.
- R6: In event counting mode the match is tested on falling edges. The interrupt and the clear happen at the first falling edge of the pin while the counter equals the compare value, never at the rising edge that brought it there. Counting resumes with the next rising edge.
- R7: The external pin passes through a two-stage synchronizer. High and low phases of at least two system clocks are each counted exactly once.
- R8: In square-wave divider mode the output starts low on each start and inverts on every match. Each half period is compare×2^E system clocks.
- R9: While run is 0, the counter is held at zero, the divider output is low and no interrupt is raised. A new start clears the prescaler, so timing restarts from zero.
- R10: The interrupt output is high for exactly one clock cycle per match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control byte, 1 selects compare value |
| wr_data | input | 8 | Write data |
| evt_in | input | 1 | External event pin, asynchronous |
| div_out | output | 1 | Square-wave divider output |
| irq | output | 1 | One-cycle match interrupt pulse |

## Verification
The bench sweeps all sixteen clock-select and range combinations. It checks the cycle of the first interrupt against 2^E, so a wrong divisor table or an extra register stage in the tick path moves that cycle. It checks the event-mode split between rising-edge counting and falling-edge matching by holding the pin high after the count reaches the compare value. A design that matched on the rising edge would raise the interrupt too early. A design that ignored the timer tick wrongly would count in event mode with the pin idle. Further checks cover the compare value of zero, the first and second toggle times of the divider output, and a restart part-way through a period. A design that did not clear the prescaler or counter on restart would interrupt early. A design that kept the output level across a stop would leave the pin high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W  = 8;
    localparam int TMR_CSEL_W = 3;
    localparam int TMR_PRE_W  = 12;
    localparam int TMR_EXP_W  = 4;

    localparam logic [TMR_EXP_W-1:0] EXP_SLOW   = 4'd11;
    localparam logic [TMR_EXP_W-1:0] EXP_MID    = 4'd7;
    localparam logic [TMR_EXP_W-1:0] EXP_FAST   = 4'd5;
    localparam logic [TMR_EXP_W-1:0] EXP_FASTER = 4'd3;

    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_EVENT  = 2'b01,
        MODE_DIVOUT = 2'b10,
        MODE_ALT    = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_CMP  = 1'b1
    } tmr_reg_e;

    typedef struct packed {
        logic                  run;
        logic                  range;
        logic [TMR_CSEL_W-1:0] csel;
        tmr_mode_e             mode;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t tmr_unpack_ctrl(input logic [7:0] b);
        tmr_ctrl_t c;
        c.run   = b[7];
        c.range = b[5];
        c.csel  = b[4:2];
        c.mode  = tmr_mode_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [TMR_EXP_W-1:0] tmr_div_exp(
        input logic [TMR_CSEL_W-1:0] csel,
        input logic                  range
    );
        logic [TMR_EXP_W-1:0] base;
        case (csel)
            3'd0:    base = EXP_SLOW;
            3'd1:    base = EXP_MID;
            3'd2:    base = EXP_FAST;
            default: base = EXP_FASTER;
        endcase
        return base + {{(TMR_EXP_W-1){1'b0}}, range};
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    output tmr_ctrl_t        ctrl,
    output logic [CNT_W-1:0] cmp
);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             unused_spare;

    assign unused_spare = wr_data[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (tmr_reg_e'(wr_addr) == REG_CTRL) begin
                ctrl_q <= tmr_unpack_ctrl(wr_data);
            end else begin
                cmp_q <= wr_data[CNT_W-1:0];
            end
        end
    end

    assign ctrl = ctrl_q;
    assign cmp  = cmp_q;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = TMR_PRE_W,
    parameter int EXP_W = TMR_EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PRE_W'(1);
        end
    end

    always_comb begin
        mask = (PRE_W'(1) << exp_sel) - PRE_W'(1);
        tick = run && ((pcnt_q & mask) == mask);
    end

    assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_no_tick_at_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !tick);

endmodule

// File: rtl/tmr_evsync.sv
module tmr_evsync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_N-1:0] stage_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < SYNC_N; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[SYNC_N-1];
    end

    assign rise = stage_q[SYNC_N-1] && !prev_q;
    assign fall = !stage_q[SYNC_N-1] && prev_q;

    assert_edge_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}));

    assert_edge_single_R7: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    input  logic             tick,
    input  logic             rise,
    input  logic             fall,
    output logic             irq,
    output logic             pdo
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;
    logic             adv;
    logic             clr;
    logic             irq_q;
    logic             pdo_q;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        hit     = (cmp == '0) || (cnt_inc == cmp);
        adv     = 1'b0;
        clr     = 1'b0;
        case (mode)
            MODE_EVENT: begin
                adv = rise;
                clr = fall && (cnt_q == cmp);
            end
            default: begin
                adv = tick;
                clr = tick && hit;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= run && clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pdo_q <= 1'b0;
        end else if (clr && (mode == MODE_DIVOUT)) begin
            pdo_q <= !pdo_q;
        end
    end

    assign irq = irq_q;
    assign pdo = pdo_q;

    assert_irq_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!irq_q && !pdo_q && cnt_q == '0));

    assert_toggle_with_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(pdo_q)) |-> irq_q);

    assert_event_match_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_q && mode == MODE_EVENT && $past(mode) == MODE_EVENT) |-> $past(fall));

endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int CNT_W  = TMR_CNT_W,
    parameter int PRE_W  = TMR_PRE_W,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       evt_in,
    output logic       div_out,
    output logic       irq
);

    localparam int EXP_W = TMR_EXP_W;

    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] cmp;
    logic [EXP_W-1:0] exp_sel;
    logic             tick;
    logic             rise;
    logic             fall;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .cmp     (cmp)
    );

    assign exp_sel = tmr_div_exp(ctrl.csel, ctrl.range);

    tmr_prescaler #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .exp_sel (exp_sel),
        .tick    (tick)
    );

    tmr_evsync #(.SYNC_N(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (evt_in),
        .rise (rise),
        .fall (fall)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .mode (ctrl.mode),
        .cmp  (cmp),
        .tick (tick),
        .rise (rise),
        .fall (fall),
        .irq  (irq),
        .pdo  (div_out)
    );

    assert_event_ignores_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_EVENT && $past(ctrl.mode) == MODE_EVENT && irq) |-> $past(fall));

endmodule

// File: tb/tmr_top_bench.sv
module tmr_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       evt_in = 1'b0;
    logic       div_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int irq_total = 0;
    int last_irq = -1;
    int t0 = 0;
    bit done = 1'b0;

    always #4 clk = !clk;

    tmr_top u_tmr_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt_in  (evt_in),
        .div_out (div_out),
        .irq     (irq)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (irq) begin
            irq_total = irq_total + 1;
            last_irq  = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        t0 = cyc;
        wr_en = 1'b0;
    endtask

    task automatic adv_to(input int target);
        while (cyc < target) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk); evt_in = 1'b1;
        repeat (hi) @(negedge clk);
        evt_in = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    function automatic logic [7:0] cbyte(input bit run, input bit rng,
                                         input int cs, input int md);
        return {run, 1'b0, rng, cs[2:0], md[1:0]};
    endfunction

    function automatic int period(input int cs, input bit rng);
        int e;
        e = (cs == 0) ? 11 : (cs == 1) ? 7 : (cs == 2) ? 5 : 3;
        return 1 << (e + (rng ? 1 : 0));
    endfunction

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq == 1'b0, "R9 reset irq", irq, 0);
        chk(div_out == 1'b0, "R9 reset div_out", div_out, 0);

        // R2 / R1: sweep every clock select and range with compare 1
        wr(1'b1, 8'd1);
        for (int r = 0; r < 2; r++) begin
            for (int cs = 0; cs < 8; cs++) begin
                int d;
                d = period(cs, r[0]);
                wr(1'b0, cbyte(0, r[0], cs, 0));
                base = irq_total;
                wr(1'b0, cbyte(1, r[0], cs, 0));
                adv_to(t0 + d + 2);
                chk(irq_total == base + 1, "R2 one tick count", irq_total - base, 1);
                chk(last_irq == t0 + 1 + d, "R2 first tick time", last_irq - t0, d + 1);
            end
        end

        // R3 / R10: compare 5, period 8 (code 3)
        wr(1'b0, cbyte(0, 0, 3, 0));
        wr(1'b1, 8'd5);
        base = irq_total;
        wr(1'b0, cbyte(1, 0, 3, 0));
        adv_to(t0 + 40);
        chk(irq_total == base, "R3 no early irq", irq_total - base, 0);
        adv_to(t0 + 41);
        chk(irq == 1'b1 && irq_total == base + 1, "R3 first match", irq_total - base, 1);
        adv_to(t0 + 42);
        chk(irq == 1'b0, "R10 irq one cycle", irq, 0);
        adv_to(t0 + 82);
        chk(irq_total == base + 2 && last_irq == t0 + 81, "R3 second match", last_irq - t0, 81);

        // R4: compare 0 gives a match every tick
        wr(1'b0, cbyte(0, 0, 3, 3));
        wr(1'b1, 8'd0);
        base = irq_total;
        wr(1'b0, cbyte(1, 0, 3, 3));
        adv_to(t0 + 26);
        chk(irq_total == base + 3, "R4 every tick", irq_total - base, 3);
        chk(last_irq == t0 + 25, "R4 tick time", last_irq - t0, 25);

        // R9: restart mid-period clears prescaler and counter
        wr(1'b0, cbyte(0, 0, 3, 0));
        wr(1'b1, 8'd5);
        base = irq_total;
        wr(1'b0, cbyte(1, 0, 3, 0));
        adv_to(t0 + 20);
        wr(1'b0, cbyte(0, 0, 3, 0));
        adv_to(t0 + 50);
        chk(irq_total == base, "R9 stopped no irq", irq_total - base, 0);
        wr(1'b0, cbyte(1, 0, 3, 0));
        adv_to(t0 + 40);
        chk(irq_total == base, "R9 restart from zero", irq_total - base, 0);
        adv_to(t0 + 41);
        chk(irq_total == base + 1, "R9 restart match", irq_total - base, 1);

        // R8: divider output, compare 3, period 8 -> half period 24
        wr(1'b0, cbyte(0, 0, 3, 2));
        wr(1'b1, 8'd3);
        wr(1'b0, cbyte(1, 0, 3, 2));
        adv_to(t0 + 24);
        chk(div_out == 1'b0, "R8 starts low", div_out, 0);
        adv_to(t0 + 25);
        chk(div_out == 1'b1, "R8 first toggle", div_out, 1);
        adv_to(t0 + 48);
        chk(div_out == 1'b1, "R8 high half", div_out, 1);
        adv_to(t0 + 49);
        chk(div_out == 1'b0, "R8 second toggle", div_out, 0);
        adv_to(t0 + 73);
        chk(div_out == 1'b1, "R8 third toggle", div_out, 1);
        wr(1'b0, cbyte(0, 0, 3, 2));
        base = irq_total;
        adv_to(t0 + 3);
        chk(div_out == 1'b0, "R9 stop drives low", div_out, 0);
        adv_to(t0 + 60);
        chk(irq_total == base, "R9 stop no irq", irq_total - base, 0);

        // R5 / R6 / R7: event counting, compare 3
        wr(1'b1, 8'd3);
        base = irq_total;
        wr(1'b0, cbyte(1, 0, 3, 1));
        adv_to(t0 + 100);
        chk(irq_total == base, "R5 ticks ignored", irq_total - base, 0);
        pulse(2, 2);
        pulse(2, 2);
        @(negedge clk); evt_in = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        chk(irq_total == base, "R6 no irq on rise", irq_total - base, 0);
        evt_in = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk(irq_total == base + 1, "R6 irq on fall", irq_total - base, 1);
        for (int k = 0; k < 6; k++) pulse(2, 2);
        repeat (6) @(negedge clk);
        #1;
        chk(irq_total == base + 3, "R7 two-cycle phases counted", irq_total - base, 3);
        pulse(3, 5);
        pulse(3, 5);
        repeat (6) @(negedge clk);
        #1;
        chk(irq_total == base + 3, "R6 below compare", irq_total - base, 3);
        pulse(2, 4);
        repeat (4) @(negedge clk);
        #1;
        chk(irq_total == base + 4, "R5 resumes counting", irq_total - base, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule